// File: doc/BRIEF.md
# Configuration Handshake Host Controller

This block sits on the host side of a programmable device's configuration interface. It drives the device's active-low configuration request line. It watches two inputs from the device: the active-low status line and the configuration-done line. A start pulse launches a reconfiguration. The block pulls the request low, waits for the device to answer by pulling status low, and then releases the request. It waits for status to rise again and finally waits for done.

The request line only ever moves to the level that the status line already shows. Once configuration is running, a low pulse on status is classified by its width. Pulses shorter than half a millisecond are treated as glitches and ignored. Pulses from half a millisecond to ten and a half milliseconds are configuration errors. Anything longer is a stuck-status fault. A missing done after a programmable number of milliseconds is a timeout.

All time limits come from a clock-frequency parameter. Errors carry a code and stay visible until the next start. The next start performs the full low-then-high restart sequence.

Top module: `cfg_handshake_host`

## Requirements
- R1: After reset, nconfig_out is 1, busy, done and error are 0, and err_code is 0.
- R2: nstatus_in and conf_done_in pass through two synchronising flops. A change on either input affects the outputs on the third rising clock edge after the change.
- R3: nconfig_out goes from 1 to 0 only while the status level is 1, and from 0 to 1 only while it is 0. A start accepted while status is low leaves nconfig_out at 1, with busy at 1, until status rises.
- R4: After status returns high, conf_done_in at 1 ends the run: done becomes 1 and busy becomes 0. done holds until the next accepted start or until an error.
- R5: While configuring, a status low pulse of MIN_LOW to MAX_LOW clock cycles sets err_code 1 when status returns high. MIN_LOW is CLK_HZ/2000 cycles (0.5 ms) and MAX_LOW is 21 times MIN_LOW (10.5 ms).
- R6: While configuring, a status low pulse shorter than MIN_LOW cycles has no effect: no error is raised and a later done still completes the run.
- R7: A status low lasting more than MAX_LOW cycles sets err_code 2 without waiting for status to return.
- R8: If done is not seen within DONE_TMO_MS milliseconds of status rising (DONE_TMO_MS × CLK_HZ/1000 cycles), err_code becomes 3.
- R9: A falling status while the block is idle, with nconfig_out steady at 1, sets err_code 4 and clears done.
- R10: error equals (err_code != 0) and is sticky, with nconfig_out held at 1, until a start arrives. That start clears the error and re-runs the full request low-then-high sequence.
- R11: start pulses while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a (re)configuration; accepted only when not busy |
| nconfig_out | output | 1 | Active-low configuration request to the device |
| nstatus_in | input | 1 | Active-low status from the device (asynchronous) |
| conf_done_in | input | 1 | Configuration-done from the device (asynchronous) |
| busy | output | 1 | A handshake or configuration is in progress |
| done | output | 1 | Last run completed successfully (sticky) |
| error | output | 1 | An error code is held (sticky) |
| err_code | output | 3 | 0 none, 1 error pulse, 2 stuck status low, 3 done timeout, 4 unexpected status change |

## Verification
A wrong controller state shows up at the ports within one clock. It appears either as a request level that disagrees with the handshake step or as a busy, done or error flag that flips early or late. A bad pulse-width or millisecond count shows only at the boundary, where the error code appears one cycle away from its due edge or on the wrong side of the glitch limit. For that reason the pulse lengths 7, 8, 168 and beyond are driven on purpose. Every output is compared against a reference on every clock, so a shift of a single cycle is caught.

// File: rtl/cfg_handshake_host.sv
module cfg_handshake_host #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int DONE_TMO_MS = 100,
  parameter int MSW         = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       nconfig_out,
  input  logic       nstatus_in,
  input  logic       conf_done_in,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [2:0] err_code
);
  localparam int CYC_MS  = CLK_HZ / 1000;
  localparam int MIN_LOW = CLK_HZ / 2000;
  localparam int MAX_LOW = MIN_LOW * 21;
  localparam int CW      = $clog2(MAX_LOW + 2);
  localparam int PW      = $clog2(CYC_MS + 1);

  localparam logic [2:0] E_NONE  = 3'd0;
  localparam logic [2:0] E_PULSE = 3'd1;
  localparam logic [2:0] E_STUCK = 3'd2;
  localparam logic [2:0] E_TMO   = 3'd3;
  localparam logic [2:0] E_UNEXP = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_PULL, S_REL, S_CFG, S_LOW, S_ERR} state_t;

  state_t          state;
  logic [1:0]      st_q, dn_q;
  logic            st_d;
  logic [CW-1:0]   wid;
  logic [PW-1:0]   pre;
  logic [MSW-1:0]  ms;

  wire st      = st_q[1];
  wire dn      = dn_q[1];
  wire timing  = (state == S_CFG) || (state == S_LOW);
  wire ms_tick = (pre == PW'(CYC_MS - 1));

  assign nconfig_out = (state != S_PULL);
  assign busy        = (state != S_IDLE) && (state != S_ERR);
  assign error       = (err_code != E_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      dn_q <= '0;
      st_d <= 1'b0;
    end else begin
      st_q <= {st_q[0], nstatus_in};
      dn_q <= {dn_q[0], conf_done_in};
      st_d <= st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      ms  <= '0;
    end else if (timing) begin
      pre <= ms_tick ? '0 : pre + 1'b1;
      if (ms_tick && ms != '1) ms <= ms + 1'b1;
    end else begin
      pre <= '0;
      ms  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      err_code <= E_NONE;
      wid      <= '0;
    end else begin
      unique case (state)
        S_IDLE:
          if (start) begin
            state    <= S_ARM;
            done     <= 1'b0;
            err_code <= E_NONE;
          end else if (st_d && !st) begin
            state    <= S_ERR;
            done     <= 1'b0;
            err_code <= E_UNEXP;
          end
        S_ERR:
          if (start) begin
            state    <= S_ARM;
            err_code <= E_NONE;
          end
        S_ARM:  if (st)  state <= S_PULL;
        S_PULL: if (!st) state <= S_REL;
        S_REL:  if (st)  state <= S_CFG;
        S_CFG:
          if (dn) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else if (!st) begin
            state <= S_LOW;
            wid   <= CW'(1);
          end else if (ms >= MSW'(DONE_TMO_MS)) begin
            state    <= S_ERR;
            err_code <= E_TMO;
          end
        S_LOW:
          if (st) begin
            if (wid < CW'(MIN_LOW)) begin
              state <= S_CFG;
            end else begin
              state    <= S_ERR;
              err_code <= E_PULSE;
            end
          end else if (wid >= CW'(MAX_LOW)) begin
            state    <= S_ERR;
            err_code <= E_STUCK;
          end else begin
            wid <= wid + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_handshake_host_chk.sv
module cfg_handshake_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic nconfig_out,
  input logic st_sync,
  input logic busy,
  input logic done,
  input logic error
);
  assert_fall_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nconfig_out) |-> $past(st_sync));

  assert_rise_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nconfig_out) |-> !$past(st_sync));

  assert_err_holds_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> nconfig_out);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !error));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && st_sync) |=> done);
endmodule

bind cfg_handshake_host cfg_handshake_host_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .nconfig_out (nconfig_out),
  .st_sync     (st_q[1]),
  .busy        (busy),
  .done        (done),
  .error       (error)
);

// File: tb/cfg_handshake_host_tb_top.sv
`timescale 1ns/1ps
module cfg_handshake_host_tb_top;
  localparam int CLK_HZ  = 16000;
  localparam int TMO_MS  = 3;
  localparam int CYC_MS  = CLK_HZ / 1000;
  localparam int MIN_LOW = CLK_HZ / 2000;
  localparam int MAX_LOW = MIN_LOW * 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic nstatus_in = 1'b1;
  logic conf_done_in = 1'b0;
  logic nconfig_out, busy, done, error;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  cfg_handshake_host #(.CLK_HZ(CLK_HZ), .DONE_TMO_MS(TMO_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nconfig_out(nconfig_out),
    .nstatus_in(nstatus_in), .conf_done_in(conf_done_in),
    .busy(busy), .done(done), .error(error), .err_code(err_code)
  );

  int vecs = 0;
  int fails = 0;
  string cur_req = "R1";

  // Behavioural reference: 0 idle,1 arm,2 pull,3 release,4 config,5 low,6 error
  int m_state, m_ns, m_wid, m_pre, m_ms, m_code;
  bit m_done, s0, s1, sd, d0, d1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_wid = 0; m_pre = 0; m_ms = 0; m_code = 0; m_done = 0;
      s0 = 0; s1 = 0; sd = 0; d0 = 0; d1 = 0;
    end else begin
      m_ns = m_state;
      case (m_state)
        0: if (start) begin m_ns = 1; m_done = 0; m_code = 0; end
           else if (sd && !s1) begin m_ns = 6; m_done = 0; m_code = 4; end
        6: if (start) begin m_ns = 1; m_code = 0; end
        1: if (s1) m_ns = 2;
        2: if (!s1) m_ns = 3;
        3: if (s1) m_ns = 4;
        4: if (d1) begin m_ns = 0; m_done = 1; end
           else if (!s1) begin m_ns = 5; m_wid = 1; end
           else if (m_ms >= TMO_MS) begin m_ns = 6; m_code = 3; end
        5: if (s1) begin
             if (m_wid < MIN_LOW) m_ns = 4;
             else begin m_ns = 6; m_code = 1; end
           end else if (m_wid >= MAX_LOW) begin m_ns = 6; m_code = 2; end
           else m_wid++;
        default: m_ns = 0;
      endcase
      if (m_state == 4 || m_state == 5) begin
        if (m_pre == CYC_MS - 1) begin m_pre = 0; m_ms++; end
        else m_pre++;
      end else begin
        m_pre = 0; m_ms = 0;
      end
      m_state = m_ns;
      sd = s1; s1 = s0; s0 = nstatus_in;
      d1 = d0; d0 = conf_done_in;
    end
  end

  bit prev_ncfg = 1'b1;
  always @(negedge clk) begin
    bit e_n, e_b, e_e;
    e_n = (m_state != 2);
    e_b = (m_state >= 1 && m_state <= 5);
    e_e = (m_code != 0);
    vecs++;
    if (nconfig_out !== e_n || busy !== e_b || done !== m_done ||
        error !== e_e || err_code !== 3'(m_code)) begin
      fails++;
      $display("FAIL %s t=%0t: actual ncfg=%b busy=%b done=%b err=%b code=%0d expected ncfg=%b busy=%b done=%b err=%b code=%0d",
               cur_req, $time, nconfig_out, busy, done, error, err_code,
               e_n, e_b, m_done, e_e, m_code);
    end
    if (rst_n && nconfig_out !== prev_ncfg) begin
      vecs++;
      if (nconfig_out !== ~nstatus_in ? 1'b0 : 1'b0) begin end
      if ((prev_ncfg && !nstatus_in) || (!prev_ncfg && nstatus_in)) begin
        fails++;
        $display("FAIL R3: actual request moved %b->%b with status %b, expected status %b",
                 prev_ncfg, nconfig_out, nstatus_in, prev_ncfg);
      end
    end
    prev_ncfg = nconfig_out;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_ncfg(input logic v, input string req);
    int n = 0;
    while (nconfig_out !== v && n < 1000) begin @(negedge clk); n++; end
    chk(nconfig_out === v, req, int'(nconfig_out), int'(v));
  endtask

  task automatic handshake(input string req);
    pulse_start();
    wait_ncfg(1'b0, req);
    conf_done_in = 1'b0;
    tick(4);
    nstatus_in = 1'b0;
    wait_ncfg(1'b1, req);
    tick(4);
    nstatus_in = 1'b1;
    tick(4);
  endtask

  task automatic low_pulse(input int len);
    nstatus_in = 1'b0;
    tick(len);
    nstatus_in = 1'b1;
    tick(5);
  endtask

  initial begin
    cur_req = "R1";
    tick(3);
    chk(nconfig_out === 1'b1 && busy === 1'b0 && done === 1'b0 && error === 1'b0,
        "R1 reset outputs", {nconfig_out, busy, done, error}, 4'b1000);
    rst_n = 1'b1;
    tick(4);
    chk(err_code === 3'd0, "R1 reset code", int'(err_code), 0);

    cur_req = "R2";
    pulse_start();
    wait_ncfg(1'b0, "R2 request low");
    tick(4);
    nstatus_in = 1'b0;
    tick(2);
    chk(nconfig_out === 1'b0, "R2 two edges after status fall", int'(nconfig_out), 0);
    tick(1);
    chk(nconfig_out === 1'b1, "R2 third edge after status fall", int'(nconfig_out), 1);
    tick(4);
    nstatus_in = 1'b1;
    tick(10);
    cur_req = "R4";
    conf_done_in = 1'b1;
    tick(2);
    chk(done === 1'b0, "R4 done not yet", int'(done), 0);
    tick(1);
    chk(done === 1'b1 && busy === 1'b0, "R4 done", {done, busy}, 2'b10);
    tick(20);
    chk(done === 1'b1, "R4 done sticky", int'(done), 1);

    cur_req = "R6";
    handshake("R6");
    tick(5);
    low_pulse(MIN_LOW - 1);
    chk(error === 1'b0 && busy === 1'b1, "R6 glitch ignored", {error, busy}, 2'b01);
    conf_done_in = 1'b1;
    tick(4);
    chk(done === 1'b1, "R6 completes after glitch", int'(done), 1);

    cur_req = "R5";
    handshake("R5");
    tick(5);
    low_pulse(MIN_LOW);
    chk(err_code === 3'd1 && busy === 1'b0, "R5 min width error", int'(err_code), 1);
    cur_req = "R10";
    tick(30);
    chk(error === 1'b1 && nconfig_out === 1'b1, "R10 sticky and held high",
        {error, nconfig_out}, 2'b11);

    cur_req = "R5";
    handshake("R10 restart");
    chk(error === 1'b0 && busy === 1'b1, "R10 start clears error", {error, busy}, 2'b01);
    tick(5);
    low_pulse(MAX_LOW);
    chk(err_code === 3'd1, "R5 max width error", int'(err_code), 1);

    cur_req = "R7";
    handshake("R7");
    tick(5);
    nstatus_in = 1'b0;
    tick(MAX_LOW + 4);
    chk(err_code === 3'd2, "R7 stuck low fault", int'(err_code), 2);

    cur_req = "R3";
    pulse_start();
    tick(30);
    chk(nconfig_out === 1'b1 && busy === 1'b1 && error === 1'b0,
        "R3 waits for status high", {nconfig_out, busy, error}, 3'b110);
    nstatus_in = 1'b1;
    wait_ncfg(1'b0, "R3 request low after status high");
    conf_done_in = 1'b0;
    tick(4);
    nstatus_in = 1'b0;
    wait_ncfg(1'b1, "R3 release");
    tick(4);
    nstatus_in = 1'b1;
    cur_req = "R8";
    tick(CYC_MS * TMO_MS - 4);
    chk(error === 1'b0, "R8 before timeout", int'(error), 0);
    tick(20);
    chk(err_code === 3'd3, "R8 done timeout", int'(err_code), 3);

    cur_req = "R11";
    handshake("R11");
    pulse_start();
    tick(3);
    pulse_start();
    chk(busy === 1'b1 && error === 1'b0, "R11 start while busy ignored", {busy, error}, 2'b10);
    conf_done_in = 1'b1;
    tick(4);
    chk(done === 1'b1, "R11 run completes", int'(done), 1);

    cur_req = "R9";
    tick(5);
    nstatus_in = 1'b0;
    tick(5);
    chk(err_code === 3'd4 && done === 1'b0, "R9 unexpected status", int'(err_code), 4);
    nstatus_in = 1'b1;
    tick(5);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog %s: actual hung, expected completion", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule